// File: doc/BRIEF.md
# Sixteen-Bit Iterative Multiply Unit with Carry/Overflow Flags

This block multiplies two 16-bit values over several clock cycles and reports the result together with a carry flag and an overflow flag. It supports four operation kinds. Two are widening forms that return a full 32-bit product as a high half and a low half: one unsigned and one signed. Two are signed truncating forms that keep only the low 16 bits. One of these multiplies the accumulator operand by the register-or-memory operand. The other multiplies the register-or-memory operand by an immediate.

A caller presents the operands and an operation code, then pulses `start_i` while the unit is idle. The datapath is a radix-2 shift-add loop that works on unsigned magnitudes. For the signed kinds it negates the 32-bit product when the operand signs differ. The result, both flags and a one-cycle `done_o` pulse appear together, and the outputs then hold until the next accepted start.

Top module: `mul16_unit`

## Requirements
- R1: With op code 0 (unsigned widening), `res_lo_o` and `res_hi_o` are the low and high halves of the 32-bit product of `acc_i` and `rm_i`, both taken as unsigned.
- R2: With op code 0, `cf_o` is 1 exactly when `res_hi_o` is nonzero, and 0 otherwise.
- R3: With op code 1 (signed widening), `res_hi_o:res_lo_o` is the 32-bit two's-complement product of `acc_i` and `rm_i`, both taken as signed.
- R4: With op code 1, `cf_o` is 0 exactly when `res_hi_o` equals 16 copies of bit 15 of `res_lo_o`, and 1 otherwise.
- R5: With op code 2 (signed two-operand truncating), `res_lo_o` is the low 16 bits of the signed product `acc_i` × `rm_i`, and `res_hi_o` reads 0.
- R6: With op code 3 (signed three-operand truncating), `res_lo_o` is the low 16 bits of the signed product `rm_i` × `imm_i`, `acc_i` has no effect, and `res_hi_o` reads 0.
- R7: For op codes 2 and 3, `cf_o` is 0 when the full signed product lies within -32768..32767 inclusive, and 1 otherwise.
- R8: `of_o` always equals `cf_o`.
- R9: `done_o` is high for exactly one cycle. It rises after the 17th rising edge that follows the edge which sampled an accepted `start_i` (W+1 edges for W=16).
- R10: A `start_i` that arrives while an operation is in progress is ignored. Results and flags change only when `done_o` rises and otherwise hold their values.
- R11: While `rst_i` is high, and after it is released, `res_lo_o`, `res_hi_o`, `cf_o`, `of_o` and `done_o` are 0 until the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an operation, accepted only when idle |
| op_i | input | 2 | Operation kind: 0 unsigned widening, 1 signed widening, 2 signed two-operand, 3 signed three-operand |
| acc_i | input | 16 | Accumulator operand |
| rm_i | input | 16 | Register-or-memory operand |
| imm_i | input | 16 | Immediate operand, used by op 3 only |
| res_lo_o | output | 16 | Low half of the result |
| res_hi_o | output | 16 | High half of the result (0 for truncating forms) |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The assertions assume that `op_i`, `acc_i`, `rm_i` and `imm_i` are stable in the cycle when `start_i` is sampled with the unit idle. Operands are captured only on that edge. The assertions also assume that reset is held for at least one edge before any start. The bench changes inputs only on falling edges, holds `start_i` for a single cycle, and releases reset before issuing any operation. One scenario deliberately raises `start_i` with different operands while the unit is busy, to show that the request has no effect.

// File: rtl/mul16_pkg.sv
package mul16_pkg;
  typedef enum logic [1:0] {
    MOP_UWIDE  = 2'd0,
    MOP_SWIDE  = 2'd1,
    MOP_TRUNC2 = 2'd2,
    MOP_TRUNC3 = 2'd3
  } mop_e;

  function automatic logic op_is_signed(input mop_e op);
    return op != MOP_UWIDE;
  endfunction

  function automatic logic op_is_trunc(input mop_e op);
    return (op == MOP_TRUNC2) || (op == MOP_TRUNC3);
  endfunction
endpackage

// File: rtl/mul16_opsel.sv
module mul16_opsel
  import mul16_pkg::*;
#(
  parameter int W = 16
) (
  input  mop_e           op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   rm_i,
  input  logic [W-1:0]   imm_i,
  output logic [W-1:0]   mag_a_o,
  output logic [W-1:0]   mag_b_o,
  output logic           neg_o
);
  logic [W-1:0] raw_a, raw_b;
  logic         sgn;

  always_comb begin
    sgn = op_is_signed(op_i);
    if (op_i == MOP_TRUNC3) begin
      raw_a = rm_i;
      raw_b = imm_i;
    end else begin
      raw_a = acc_i;
      raw_b = rm_i;
    end
    mag_a_o = (sgn && raw_a[W-1]) ? (~raw_a + 1'b1) : raw_a;
    mag_b_o = (sgn && raw_b[W-1]) ? (~raw_b + 1'b1) : raw_b;
    neg_o   = sgn && (raw_a[W-1] ^ raw_b[W-1]);
  end
endmodule

// File: rtl/mul16_core.sv
module mul16_core #(
  parameter int W = 16
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           load_i,
  input  logic [W-1:0]   mag_a_i,
  input  logic [W-1:0]   mag_b_i,
  output logic [2*W-1:0] prod_o,
  output logic           fin_o,
  output logic           run_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  mcand_q;
  logic [W-1:0]  hi_q, lo_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    sum;
  logic [2*W:0]  shifted;

  always_comb begin
    sum     = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    shifted = {sum, lo_q} >> 1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      cnt_q   <= '0;
      run_o   <= 1'b0;
      fin_o   <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i) begin
        mcand_q <= mag_a_i;
        hi_q    <= '0;
        lo_q    <= mag_b_i;
        cnt_q   <= CW'(W);
        run_o   <= 1'b1;
      end else if (run_o) begin
        hi_q  <= shifted[2*W-1:W];
        lo_q  <= shifted[W-1:0];
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_o <= 1'b0;
          fin_o <= 1'b1;
        end
      end
    end
  end

  assign prod_o = {hi_q, lo_q};

  // R9: the loop never runs with an exhausted step count
  assert_cnt_live_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    run_o |-> (cnt_q != '0));
  // R9: completion is a single-cycle event
  assert_fin_pulse_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    fin_o |=> !fin_o);
endmodule

// File: rtl/mul16_flags.sv
module mul16_flags
  import mul16_pkg::*;
#(
  parameter int W = 16
) (
  input  mop_e           op_i,
  input  logic           neg_i,
  input  logic [2*W-1:0] prod_i,
  output logic [W-1:0]   res_lo_o,
  output logic [W-1:0]   res_hi_o,
  output logic           flag_o
);
  logic [2*W-1:0] full;
  logic [W:0]     top_bits;
  logic           fits;

  always_comb begin
    full     = neg_i ? (~prod_i + 1'b1) : prod_i;
    top_bits = full[2*W-1:W-1];
    fits     = (top_bits == '0) || (&top_bits);
    res_lo_o = full[W-1:0];
    res_hi_o = op_is_trunc(op_i) ? '0 : full[2*W-1:W];
    if (op_i == MOP_UWIDE) flag_o = |full[2*W-1:W];
    else                   flag_o = !fits;
  end
endmodule

// File: rtl/mul16_unit.sv
module mul16_unit
  import mul16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         start_i,
  input  logic [1:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] rm_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] res_lo_o,
  output logic [W-1:0] res_hi_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         done_o
);
  mop_e           op_in, op_q;
  logic           busy_q, neg_q, accept;
  logic [W-1:0]   mag_a, mag_b, f_lo, f_hi;
  logic           neg_w, flag_w, core_fin, core_run;
  logic [2*W-1:0] prod;

  assign op_in  = mop_e'(op_i);
  assign accept = start_i && !busy_q;

  mul16_opsel #(.W(W)) u_opsel (
    .op_i(op_in), .acc_i(acc_i), .rm_i(rm_i), .imm_i(imm_i),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg_w)
  );

  mul16_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(accept),
    .mag_a_i(mag_a), .mag_b_i(mag_b),
    .prod_o(prod), .fin_o(core_fin), .run_o(core_run)
  );

  mul16_flags #(.W(W)) u_flags (
    .op_i(op_q), .neg_i(neg_q), .prod_i(prod),
    .res_lo_o(f_lo), .res_hi_o(f_hi), .flag_o(flag_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q   <= 1'b0;
      op_q     <= MOP_UWIDE;
      neg_q    <= 1'b0;
      res_lo_o <= '0;
      res_hi_o <= '0;
      cf_o     <= 1'b0;
      of_o     <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_in;
        neg_q  <= neg_w;
      end
      if (core_fin) begin
        busy_q   <= 1'b0;
        res_lo_o <= f_lo;
        res_hi_o <= f_hi;
        cf_o     <= flag_w;
        of_o     <= flag_w;
        done_o   <= 1'b1;
      end
    end
  end

  // R9: done lasts a single cycle
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
  // R10: a start while busy does not restart the loop
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (core_run && !core_fin && start_i) |=> busy_q);
  // R10: results hold unless a completion is registered
  assert_hold_lo_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !core_fin |=> $stable(res_lo_o) && $stable(res_hi_o) && $stable(cf_o));
  // R8: both flags agree
  assert_flags_agree_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    cf_o == of_o);
  // R2: unsigned widening flag tracks a nonzero high half
  assert_uwide_flag_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && op_q == MOP_UWIDE) |-> (cf_o == (res_hi_o != '0)));
  // R4: cleared flag implies the high half is a sign extension
  assert_swide_flag_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && op_q == MOP_SWIDE && !cf_o) |-> (res_hi_o == {W{res_lo_o[W-1]}}));
  // R5: truncating forms report no high half
  assert_trunc_hi_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (done_o && op_is_trunc(op_q)) |-> (res_hi_o == '0));
endmodule

// File: tb/tb_mul16_unit.sv
module tb_mul16_unit;
  localparam int PERIOD = 10;
  localparam int LAT    = 17;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] acc = '0, rm = '0, imm = '0;
  logic [15:0] lo, hi;
  logic        cf, of, done;
  int errors = 0, checks = 0;

  always #(PERIOD/2) clk = ~clk;

  mul16_unit dut (
    .clk_i(clk), .rst_i(rst), .start_i(start), .op_i(op),
    .acc_i(acc), .rm_i(rm), .imm_i(imm),
    .res_lo_o(lo), .res_hi_o(hi), .cf_o(cf), .of_o(of), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Compute expected results from the requirement text
  task automatic model(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] im, output logic [15:0] elo,
                       output logic [15:0] ehi, output logic ef);
    int x, y, p;
    logic [31:0] u;
    if (o == 2'd0) begin
      u   = {16'd0, a} * {16'd0, b};
      elo = u[15:0]; ehi = u[31:16]; ef = (u[31:16] != 0);
    end else begin
      x = (o == 2'd3) ? int'($signed(b)) : int'($signed(a));
      y = (o == 2'd3) ? int'($signed(im)) : int'($signed(b));
      p = x * y;
      u = p;
      elo = u[15:0];
      ehi = (o == 2'd1) ? u[31:16] : 16'd0;
      ef  = !(p >= -32768 && p <= 32767);
    end
  endtask

  task automatic issue(input logic [1:0] o, input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] im);
    @(negedge clk);
    op = o; acc = a; rm = b; imm = im; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (done) break;
    end
  endtask

  task automatic run_case(input string tag, input logic [1:0] o, input logic [15:0] a,
                          input logic [15:0] b, input logic [15:0] im);
    logic [15:0] elo, ehi;
    logic ef;
    int n;
    model(o, a, b, im, elo, ehi, ef);
    issue(o, a, b, im);
    wait_done(n);
    chk({tag, " R9 latency"}, n, LAT);
    chk({tag, " lo"}, lo, elo);
    chk({tag, " hi"}, hi, ehi);
    chk({tag, " cf"}, cf, ef);
    chk({tag, " R8 of"}, of, ef);
    @(negedge clk);
    chk({tag, " R9 done drop"}, done, 0);
  endtask

  task automatic t_reset();
    chk("R11 lo", lo, 0); chk("R11 hi", hi, 0);
    chk("R11 cf", cf, 0); chk("R11 of", of, 0); chk("R11 done", done, 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] elo, ehi;
    logic ef;
    int n;
    model(2'd0, 16'h1234, 16'h0010, 16'h0, elo, ehi, ef);
    issue(2'd0, 16'h1234, 16'h0010, 16'h0);
    repeat (3) @(negedge clk);
    op = 2'd1; acc = 16'hFFFF; rm = 16'h7FFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R10 busy latency", n, LAT - 4);
    chk("R10 busy lo", lo, elo);
    chk("R10 busy hi", hi, ehi);
    repeat (25) @(negedge clk);
    chk("R10 no second done", done, 0);
    chk("R10 hold lo", lo, elo);
    chk("R10 hold hi", hi, ehi);
    chk("R10 hold cf", cf, ef);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_case("R1 R2 max", 2'd0, 16'hFFFF, 16'hFFFF, 16'h0);
    run_case("R1 R2 small", 2'd0, 16'd3, 16'd5, 16'h0);
    run_case("R1 R2 carry", 2'd0, 16'h0100, 16'h0100, 16'h0);
    run_case("R3 R4 negneg", 2'd1, 16'hFFFF, 16'hFFFF, 16'h0);
    run_case("R3 R4 neg", 2'd1, 16'hFFFF, 16'h0001, 16'h0);
    run_case("R3 R4 minmin", 2'd1, 16'h8000, 16'h8000, 16'h0);
    run_case("R3 R4 minone", 2'd1, 16'h8000, 16'h0001, 16'h0);
    run_case("R3 R4 mixed", 2'd1, 16'd300, 16'hFF38, 16'h0);
    run_case("R5 R7 min fits", 2'd2, 16'h8000, 16'h0001, 16'h0);
    run_case("R5 R7 max fits", 2'd2, 16'h7FFF, 16'h0001, 16'h0);
    run_case("R5 R7 neg min", 2'd2, 16'h8000, 16'hFFFF, 16'h0);
    run_case("R5 R7 181sq", 2'd2, 16'd181, 16'd181, 16'h0);
    run_case("R5 R7 182sq", 2'd2, 16'd182, 16'd182, 16'h0);
    run_case("R6 R7 fits", 2'd3, 16'hBEEF, 16'hFF00, 16'd128);
    run_case("R6 R7 over", 2'd3, 16'h1234, 16'd1000, 16'hFFD8);
    run_case("R6 acc ignored", 2'd3, 16'h7FFF, 16'd7, 16'd9);
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule